// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the multiply and multiply-accumulate engine of a small processor core. It keeps a private 64-bit accumulator, exposed as a high and a low 32-bit half, and carries out four signed operations on two 32-bit operands: a 16x16 multiply into the low half, a 32x32 multiply into the whole accumulator, a word accumulate that adds a 16x16 product, and a long accumulate that adds a 32x32 product. An input flag decides whether an accumulate that leaves its range is clamped to the nearest limit or is allowed to wrap.

The core pulses `start` with an operation code, both operands and the saturation flag. The result is written into the accumulator at the next rising edge, and `done` is high during the cycle that follows. The accumulator is reached only through its own ports. A clear input zeroes it. Two write enables load either half from a shared data bus. A small state machine has two states. `S_IDLE` moves to `S_DONE` on an accepted start. `S_DONE` stays in `S_DONE` when another start is accepted and returns to `S_IDLE` otherwise.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous active-low reset, both accumulator halves read 0 and `done` is 0.
- R2: Operation code 2'b00 (16x16 multiply) writes the signed product of opa[15:0] and opb[15:0] into the low half. Operand bits 31:16 are ignored and the high half is unchanged.
- R3: Operation code 2'b01 (32x32 multiply) writes the full signed 64-bit product of opa and opb into {high, low}.
- R4: Operation code 2'b10 (word accumulate) with `sat_en`=0 adds the sign-extended 16x16 product to the 64-bit accumulator, modulo 2^64.
- R5: Operation code 2'b10 with `sat_en`=1 adds the product to the low half taken as a signed 32-bit value. The sum is clamped to 0x7FFFFFFF or 0x80000000 and the high half is unchanged.
- R6: Operation code 2'b11 (long accumulate) with `sat_en`=0 adds the signed 32x32 product to the 64-bit accumulator, modulo 2^64.
- R7: Operation code 2'b11 with `sat_en`=1 clamps the 64-bit sum to the signed 48-bit range. It gives 0x00007FFF_FFFFFFFF or 0xFFFF8000_00000000 when the sum leaves that range.
- R8: An accepted start updates the accumulator at the next rising edge, and `done` is high for exactly the following cycle. A start in consecutive cycles gives one update and one `done` cycle each.
- R9: `acc_clr` zeroes both halves at the next edge. It has priority over loads and starts, and a start in the same cycle is dropped with no `done`.
- R10: `ld_hi_we` / `ld_lo_we` write `ld_data` into the high / low half at the next edge. A start in the same cycle is dropped with no `done`, and a half that is not enabled keeps its value.
- R11: `sat_en` has no effect on the two plain multiply operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch the operation selected by `op` |
| op | input | 2 | Operation code: 00 mul16, 01 mul32, 10 word accumulate, 11 long accumulate |
| sat_en | input | 1 | Clamp accumulate results instead of wrapping |
| opa | input | 32 | First signed operand |
| opb | input | 32 | Second signed operand |
| acc_clr | input | 1 | Zero the accumulator |
| ld_hi_we | input | 1 | Load the high half from `ld_data` |
| ld_lo_we | input | 1 | Load the low half from `ld_data` |
| ld_data | input | 32 | Direct load data |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every operation result appears on `acc_hi`/`acc_lo` one edge after the start. A wrong sum, a wrong clamp bound, or an overwrite of a half that should be kept is therefore visible in the cycle that `done` is high. A wrong state in the controller shows up in the same cycle as a missing, doubled or extra `done` pulse. Any corruption of the accumulator also persists and alters every later accumulate, so an error left in the register surfaces again at the next `done`.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OP_MUL16 = 2'b00,
        OP_MUL32 = 2'b01,
        OP_MACW  = 2'b10,
        OP_MACL  = 2'b11
    } mac_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } mac_state_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int LONG_W = 32,
    parameter int WORD_W = 16
) (
    input  logic [LONG_W-1:0]   opa,
    input  logic [LONG_W-1:0]   opb,
    input  mac_op_e             op,
    output logic [2*LONG_W-1:0] prod
);
    localparam int ACC_W = 2 * LONG_W;

    logic signed [ACC_W-1:0] wa, wb, la, lb;

    always_comb begin
        wa = $signed({{(ACC_W-WORD_W){opa[WORD_W-1]}}, opa[WORD_W-1:0]});
        wb = $signed({{(ACC_W-WORD_W){opb[WORD_W-1]}}, opb[WORD_W-1:0]});
        la = $signed({{(ACC_W-LONG_W){opa[LONG_W-1]}}, opa});
        lb = $signed({{(ACC_W-LONG_W){opb[LONG_W-1]}}, opb});
        unique case (op)
            OP_MUL16, OP_MACW: prod = wa * wb;
            OP_MUL32, OP_MACL: prod = la * lb;
        endcase
    end
endmodule

// File: rtl/mac_addsat.sv
module mac_addsat
    import mac_pkg::*;
#(
    parameter int LONG_W = 32,
    parameter int SAT_L  = 48
) (
    input  logic [2*LONG_W-1:0] acc,
    input  logic [2*LONG_W-1:0] prod,
    input  mac_op_e             op,
    input  logic                sat_en,
    output logic [2*LONG_W-1:0] acc_nxt
);
    localparam int ACC_W = 2 * LONG_W;
    localparam int EW    = ACC_W + 2;
    localparam logic signed [EW-1:0] W_MAX = {{(EW-LONG_W+1){1'b0}}, {(LONG_W-1){1'b1}}};
    localparam logic signed [EW-1:0] W_MIN = {{(EW-LONG_W+1){1'b1}}, {(LONG_W-1){1'b0}}};
    localparam logic signed [EW-1:0] L_MAX = {{(EW-SAT_L+1){1'b0}}, {(SAT_L-1){1'b1}}};
    localparam logic signed [EW-1:0] L_MIN = {{(EW-SAT_L+1){1'b1}}, {(SAT_L-1){1'b0}}};

    logic signed [EW-1:0] sum_full, sum_lo, prod_x;

    always_comb begin
        prod_x   = $signed({{2{prod[ACC_W-1]}}, prod});
        sum_full = $signed({{2{acc[ACC_W-1]}}, acc}) + prod_x;
        sum_lo   = $signed({{(EW-LONG_W){acc[LONG_W-1]}}, acc[LONG_W-1:0]}) + prod_x;
        unique case (op)
            OP_MUL16: acc_nxt = {acc[ACC_W-1:LONG_W], prod[LONG_W-1:0]};
            OP_MUL32: acc_nxt = prod;
            OP_MACW: begin
                if (!sat_en)             acc_nxt = sum_full[ACC_W-1:0];
                else if (sum_lo > W_MAX) acc_nxt = {acc[ACC_W-1:LONG_W], W_MAX[LONG_W-1:0]};
                else if (sum_lo < W_MIN) acc_nxt = {acc[ACC_W-1:LONG_W], W_MIN[LONG_W-1:0]};
                else                     acc_nxt = {acc[ACC_W-1:LONG_W], sum_lo[LONG_W-1:0]};
            end
            OP_MACL: begin
                if (!sat_en)               acc_nxt = sum_full[ACC_W-1:0];
                else if (sum_full > L_MAX) acc_nxt = L_MAX[ACC_W-1:0];
                else if (sum_full < L_MIN) acc_nxt = L_MIN[ACC_W-1:0];
                else                       acc_nxt = sum_full[ACC_W-1:0];
            end
        endcase
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int LONG_W = 32,
    parameter int WORD_W = 16,
    parameter int SAT_L  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              sat_en,
    input  logic [LONG_W-1:0] opa,
    input  logic [LONG_W-1:0] opb,
    input  logic              acc_clr,
    input  logic              ld_hi_we,
    input  logic              ld_lo_we,
    input  logic [LONG_W-1:0] ld_data,
    output logic [LONG_W-1:0] acc_hi,
    output logic [LONG_W-1:0] acc_lo,
    output logic              done
);
    localparam int ACC_W = 2 * LONG_W;

    mac_state_e          state_q, state_d;
    mac_op_e             op_e;
    logic                go;
    logic [ACC_W-1:0]    acc_q, prod, acc_nxt;

    assign op_e = mac_op_e'(op);
    assign go   = start && !acc_clr && !ld_hi_we && !ld_lo_we;

    mac_mult #(.LONG_W(LONG_W), .WORD_W(WORD_W)) u_mult (
        .opa (opa),
        .opb (opb),
        .op  (op_e),
        .prod(prod)
    );

    mac_addsat #(.LONG_W(LONG_W), .SAT_L(SAT_L)) u_addsat (
        .acc    (acc_q),
        .prod   (prod),
        .op     (op_e),
        .sat_en (sat_en),
        .acc_nxt(acc_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            S_IDLE: state_d = go ? S_DONE : S_IDLE;
            S_DONE: state_d = go ? S_DONE : S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done   = (state_q == S_DONE);
        acc_hi = acc_q[ACC_W-1:LONG_W];
        acc_lo = acc_q[LONG_W-1:0];
    end

    // accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || acc_clr) begin
            acc_q <= '0;
        end else if (go) begin
            acc_q <= acc_nxt;
        end else begin
            if (ld_hi_we) acc_q[ACC_W-1:LONG_W] <= ld_data;
            if (ld_lo_we) acc_q[LONG_W-1:0]     <= ld_data;
        end
    end

    p_done_follows_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);
    p_done_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(go));
    p_mul16_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_e == OP_MUL16) |=> $stable(acc_hi));
    p_macw_sat_keeps_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_e == OP_MACW && sat_en) |=> $stable(acc_hi));
    p_macl_sat_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_e == OP_MACL && sat_en) |=>
            (acc_hi[LONG_W-1:SAT_L-LONG_W-1] == '0 || acc_hi[LONG_W-1:SAT_L-LONG_W-1] == '1));
    p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_hi == '0 && acc_lo == '0 && !done));
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        sat_en = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        acc_clr = 1'b0, ld_hi_we = 1'b0, ld_lo_we = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mac_unit u_mac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sat_en(sat_en),
        .opa(opa), .opb(opb), .acc_clr(acc_clr), .ld_hi_we(ld_hi_we),
        .ld_lo_we(ld_lo_we), .ld_data(ld_data), .acc_hi(acc_hi),
        .acc_lo(acc_lo), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic s,
                                          input logic [63:0] acc);
        longint ws, ls;
        logic signed [65:0] sf, sl;
        logic [31:0] lo;
        ws = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        ls = longint'($signed(a)) * longint'($signed(b));
        case (o)
            2'b00: return {acc[63:32], ws[31:0]};
            2'b01: return ls;
            2'b10: begin
                sf = $signed({{2{acc[63]}}, acc}) + 66'(ws);
                sl = 66'(longint'($signed(acc[31:0]))) + 66'(ws);
                if (!s) return sf[63:0];
                if (sl > 66'sh7FFFFFFF) lo = 32'h7FFFFFFF;
                else if (sl < -66'sh80000000) lo = 32'h80000000;
                else lo = sl[31:0];
                return {acc[63:32], lo};
            end
            default: begin
                sf = $signed({{2{acc[63]}}, acc}) + 66'(ls);
                if (!s) return sf[63:0];
                if (sf > 66'sh7FFF_FFFFFFFF) return 64'h00007FFF_FFFFFFFF;
                if (sf < -66'sh8000_00000000) return 64'hFFFF8000_00000000;
                return sf[63:0];
            end
        endcase
    endfunction

    task automatic load(input logic [63:0] v);
        @(negedge clk);
        ld_hi_we = 1'b1; ld_lo_we = 1'b1; ld_data = v[63:32];
        @(negedge clk);
        ld_lo_we = 1'b1; ld_hi_we = 1'b0; ld_data = v[31:0];
        @(negedge clk);
        ld_lo_we = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [1:0] o, input logic [31:0] a,
                          input logic [31:0] b, input logic s);
        logic [63:0] exp;
        exp = model(o, a, b, s, {acc_hi, acc_lo});
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b; sat_en = s;
        @(negedge clk);
        start = 1'b0;
        check({req, " result"}, {acc_hi, acc_lo}, exp);
        check({req, " done high"}, 64'(done), 64'd1);
        @(negedge clk);
        check({req, " done low"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset_r1();
        check("R1 acc", {acc_hi, acc_lo}, 64'd0);
        check("R1 done", 64'(done), 64'd0);
    endtask

    task automatic t_mul16_r2_r11();
        load(64'hCAFEF00D_11111111);
        run_op("R2", 2'b00, 32'hABCD_FFFD, 32'h1234_0007, 1'b0);
        check("R2 value", {acc_hi, acc_lo}, 64'hCAFEF00D_FFFFFFEB);
        run_op("R11 mul16 sat", 2'b00, 32'h0000_8000, 32'h0000_8000, 1'b1);
        check("R11 value", {acc_hi, acc_lo}, 64'hCAFEF00D_40000000);
    endtask

    task automatic t_mul32_r3();
        run_op("R3", 2'b01, 32'hFFFF_FFFE, 32'h7FFF_FFFF, 1'b0);
        check("R3 value", {acc_hi, acc_lo}, 64'hFFFFFFFF_00000002);
        run_op("R11 mul32 sat", 2'b01, 32'h8000_0000, 32'h8000_0000, 1'b1);
        check("R11 mul32 value", {acc_hi, acc_lo}, 64'h40000000_00000000);
    endtask

    task automatic t_macw_r4_r5();
        load(64'h7FFFFFFF_FFFFFFFF);
        run_op("R4 wrap", 2'b10, 32'h1, 32'h1, 1'b0);
        check("R4 value", {acc_hi, acc_lo}, 64'h80000000_00000000);
        load(64'h12345678_7FFF0000);
        run_op("R5 pos clamp", 2'b10, 32'h7FFF, 32'h7FFF, 1'b1);
        check("R5 pos value", {acc_hi, acc_lo}, 64'h12345678_7FFFFFFF);
        load(64'h00000001_80000100);
        run_op("R5 neg clamp", 2'b10, 32'h7FFF, 32'h8000, 1'b1);
        check("R5 neg value", {acc_hi, acc_lo}, 64'h00000001_80000000);
        run_op("R5 in range", 2'b10, 32'h2, 32'h3, 1'b1);
        check("R5 in range value", {acc_hi, acc_lo}, 64'h00000001_80000006);
    endtask

    task automatic t_macl_r6_r7();
        load(64'h0);
        run_op("R6", 2'b11, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op("R6 second", 2'b11, 32'h8000_0000, 32'h8000_0000, 1'b0);
        check("R6 value", {acc_hi, acc_lo}, 64'h80000000_00000000);
        load(64'h00007FFF_FFFF0000);
        run_op("R7 pos clamp", 2'b11, 32'h10000, 32'h10000, 1'b1);
        check("R7 pos value", {acc_hi, acc_lo}, 64'h00007FFF_FFFFFFFF);
        load(64'hFFFF8000_00000000);
        run_op("R7 neg clamp", 2'b11, 32'hFFFF_FFFF, 32'h1, 1'b1);
        check("R7 neg value", {acc_hi, acc_lo}, 64'hFFFF8000_00000000);
    endtask

    task automatic t_back_to_back_r8();
        load(64'h0);
        @(negedge clk);
        start = 1'b1; op = 2'b11; opa = 32'd2; opb = 32'd3; sat_en = 1'b0;
        @(negedge clk);
        check("R8 first result", {acc_hi, acc_lo}, 64'd6);
        check("R8 first done", 64'(done), 64'd1);
        @(negedge clk);
        start = 1'b0;
        check("R8 second result", {acc_hi, acc_lo}, 64'd12);
        check("R8 second done", 64'(done), 64'd1);
        @(negedge clk);
        check("R8 done drops", 64'(done), 64'd0);
    endtask

    task automatic t_clear_r9();
        load(64'h55555555_AAAAAAAA);
        @(negedge clk);
        acc_clr = 1'b1; ld_hi_we = 1'b1; ld_data = 32'hFFFF_FFFF;
        start = 1'b1; op = 2'b01; opa = 32'd5; opb = 32'd7;
        @(negedge clk);
        acc_clr = 1'b0; ld_hi_we = 1'b0; start = 1'b0;
        check("R9 cleared", {acc_hi, acc_lo}, 64'd0);
        check("R9 no done", 64'(done), 64'd0);
    endtask

    task automatic t_load_r10();
        load(64'h01234567_89ABCDEF);
        check("R10 both halves", {acc_hi, acc_lo}, 64'h01234567_89ABCDEF);
        @(negedge clk);
        ld_hi_we = 1'b1; ld_data = 32'hDEAD_BEEF;
        start = 1'b1; op = 2'b01; opa = 32'd9; opb = 32'd9;
        @(negedge clk);
        ld_hi_we = 1'b0; start = 1'b0;
        check("R10 hi only", {acc_hi, acc_lo}, 64'hDEADBEEF_89ABCDEF);
        check("R10 start dropped", 64'(done), 64'd0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_mul16_r2_r11();
        t_mul32_r3();
        t_macw_r4_r5();
        t_macl_r6_r7();
        t_back_to_back_r8();
        t_clear_r9();
        t_load_r10();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule